// File: doc/BRIEF.md
# Four-Port Eight-Bank Memory Crossbar

This block joins four memory ports to eight word-interleaved data memory banks so that every port can reach every bank. Each port takes its byte address from its own internal address register, loaded through a separate strobe in some earlier cycle. A bundle of up to four accesses (loads or stores, byte, halfword or word) is issued in one cycle. When all enabled ports fall in different banks the whole bundle is served in that cycle. When two or more ports hit one bank, the block raises a stall and serves the colliding ports one per cycle, lowest port first. It stalls for no more cycles than the busiest bank needs.

Load data comes back through a two-stage pipeline. It is taken from the bank the port used, moved down so the addressed byte or halfword lands in the low bits, and zero-extended. Each bank holds its most recent store in a one-entry buffer that drains into the bank memory on the next cycle. A load that arrives while the matching store is still in that buffer takes the newer bytes from the buffer. Bank storage is a plain synchronous-read memory per bank.

Top module: `bank_xbar`

## Requirements
- R1: A port's address register is written at the clock edge that ends a cycle with its load strobe high. A bundle issued in that same cycle still uses the register's previous value.
- R2: Address bits [1:0] give the byte offset, bits [4:2] give the bank and bits [11:5] give the row. A word written through one port can be read back through any other port.
- R3: A bundle whose enabled ports all use different banks keeps `stall` low. Every enabled port gets `resp_valid` high for exactly one cycle, two cycles after the issue cycle.
- R4: If the largest number of enabled ports sharing one bank is N > 1, `stall` is high for exactly N-1 consecutive cycles, starting in the issue cycle.
- R5: Ports sharing a bank are served in ascending port order. A port with k lower-numbered enabled ports in its bank responds k+2 cycles after issue.
- R6: From the cycle after a stalling issue until the bundle has been fully served, `issue`, `acc_en`, `acc_store`, `acc_size` and `acc_wdata` have no effect. The captured bundle completes unchanged.
- R7: Size code 0 is a byte, 1 is a halfword, and 2 or 3 is a word. A byte store writes only the byte at the offset. A halfword store writes the two bytes at offset 0 or 2. A word store writes the whole word and ignores the offset.
- R8: A load returns the addressed byte in [7:0] or halfword in [15:0], with the upper bits zero. A word load returns the whole word and ignores the offset. Lane i of a word is byte address base+i.
- R9: A halfword access at offset 1 or 3 sets `resp_err` with its response, writes nothing, and returns zero data.
- R10: A load served in the cycle right after a store to the same bank and row returns that store's bytes merged over the older memory contents.
- R11: A store's response carries zero data and `resp_err` low, unless R9 applies.
- R12: During and right after reset, `stall`, `resp_valid`, `resp_err` and `resp_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mar_load | input | NPORT | Per-port strobe that writes the address register |
| mar_value | input | NPORT*AW | New byte address for each port, port p in bits [p*AW +: AW] |
| issue | input | 1 | Presents a bundle of accesses this cycle |
| acc_en | input | NPORT | Port takes part in the bundle |
| acc_store | input | NPORT | 1 store, 0 load |
| acc_size | input | NPORT*2 | Access size code per port (R7) |
| acc_wdata | input | NPORT*DW | Store data, low-aligned, per port |
| stall | output | 1 | Bundle needs further cycles; hold the pipeline |
| resp_valid | output | NPORT | Access of that port completes its response this cycle |
| resp_err | output | NPORT | Misaligned halfword flag |
| resp_data | output | NPORT*DW | Aligned, zero-extended load data |

## Verification
The assertions check, on every cycle, that a stall is always followed by a cycle still working off the bundle and that each such cycle retires at least one pending port. They also check that the captured bundle does not change while it is served, that every grant yields a response exactly two cycles later, and that error and byte responses carry zero upper data. Only the bench's scenarios can show that the stall length is the minimum for a given collision pattern, that data lands in the right bank lane and row, that priority order holds across ports, that buffered stores bypass into loads, and that same-cycle address loads do not leak into the current bundle.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

  // access size codes on acc_size
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD3 = 2'd3
  } acc_size_e;

endpackage

// File: rtl/mxb_arbiter.sv
// Per-bank fixed-priority pick: lowest-numbered active port wins its bank.
module mxb_arbiter #(
  parameter int NPORT = 4,
  parameter int NBANK = 8,
  parameter int BW    = 3
) (
  input  logic [NPORT-1:0]             active,
  input  logic [NPORT-1:0][BW-1:0]     bank_sel,
  output logic [NBANK-1:0][NPORT-1:0]  pick,
  output logic [NPORT-1:0]             grant
);

  always_comb begin
    pick = '0;
    for (int b = 0; b < NBANK; b++) begin
      for (int p = 0; p < NPORT; p++) begin
        if (active[p] && (bank_sel[p] == BW'(b)) && (pick[b] == '0)) begin
          pick[b][p] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    grant = '0;
    for (int b = 0; b < NBANK; b++) begin
      grant = grant | pick[b];
    end
  end

endmodule

// File: rtl/mxb_bank.sv
// One interleaved bank: synchronous-read memory plus a one-entry store buffer
// that drains into the memory on the following cycle.
module mxb_bank #(
  parameter int DW = 32,
  parameter int RW = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              we,
  input  logic [RW-1:0]     row,
  input  logic [DW-1:0]     wdata,
  input  logic [DW/8-1:0]   be,
  output logic [DW-1:0]     rdata
);
  localparam int LANES = DW / 8;
  localparam int ROWS  = 1 << RW;

  logic [DW-1:0]    mem [ROWS];
  logic [DW-1:0]    q;
  logic             sb_valid;
  logic [RW-1:0]    sb_row;
  logic [DW-1:0]    sb_data;
  logic [LANES-1:0] sb_be;
  logic [LANES-1:0] byp_be;
  logic [DW-1:0]    byp_data;

  // memory array: byte-enabled write from the buffer, read-first load
  always_ff @(posedge clk) begin
    if (sb_valid) begin
      for (int i = 0; i < LANES; i++) begin
        if (sb_be[i]) mem[sb_row][8*i +: 8] <= sb_data[8*i +: 8];
      end
    end
    if (en && !we) q <= mem[row];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sb_valid <= 1'b0;
      byp_be   <= '0;
    end else begin
      sb_valid <= en && we && (be != '0);
      if (en && !we) byp_be <= (sb_valid && (sb_row == row)) ? sb_be : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (en && we) begin
      sb_row  <= row;
      sb_data <= wdata;
      sb_be   <= be;
    end
    if (en && !we) byp_data <= sb_data;
  end

  // merge buffered bytes over the memory word
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rdata[8*i +: 8] = byp_be[i] ? byp_data[8*i +: 8] : q[8*i +: 8];
  end

  // R9: an access with no byte enabled leaves nothing to drain
  a_r9_no_empty_write: assert property (@(posedge clk) disable iff (rst)
    (en && we && (be == '0)) |=> !sb_valid);

endmodule

// File: rtl/mxb_load_align.sv
// Moves the addressed byte or halfword to the low bits and zero-extends it.
module mxb_load_align
  import mxb_pkg::*;
#(
  parameter int DW   = 32,
  parameter int OFFW = 2
) (
  input  logic [DW-1:0]   word,
  input  logic [OFFW-1:0] off,
  input  logic [1:0]      size,
  input  logic            kill,
  output logic [DW-1:0]   result
);
  logic [OFFW-1:0] half_off;
  logic [DW-1:0]   sh_byte;
  logic [DW-1:0]   sh_half;

  always_comb begin
    half_off = off;
    half_off[0] = 1'b0;
    sh_byte = word >> {off, 3'b000};
    sh_half = word >> {half_off, 3'b000};
    case (size)
      SZ_BYTE: result = DW'(sh_byte[7:0]);
      SZ_HALF: result = DW'(sh_half[15:0]);
      default: result = word;
    endcase
    if (kill) result = '0;
  end

endmodule

// File: rtl/bank_xbar.sv
module bank_xbar
  import mxb_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int NBANK = 8,
  parameter int DW    = 32,
  parameter int AW    = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPORT-1:0]    mar_load,
  input  logic [NPORT*AW-1:0] mar_value,
  input  logic                issue,
  input  logic [NPORT-1:0]    acc_en,
  input  logic [NPORT-1:0]    acc_store,
  input  logic [NPORT*2-1:0]  acc_size,
  input  logic [NPORT*DW-1:0] acc_wdata,
  output logic                stall,
  output logic [NPORT-1:0]    resp_valid,
  output logic [NPORT-1:0]    resp_err,
  output logic [NPORT*DW-1:0] resp_data
);
  localparam int LANES = DW / 8;
  localparam int OFFW  = $clog2(LANES);
  localparam int BW    = $clog2(NBANK);
  localparam int RW    = AW - OFFW - BW;

  // bundle control
  logic [NPORT-1:0] pending, active, grant, pend_next;
  logic             busy, accept;

  // address registers and captured bundle
  logic [NPORT-1:0][AW-1:0] mar_q, hold_addr, cur_addr;
  logic [NPORT-1:0]         hold_store, cur_store;
  logic [NPORT-1:0][1:0]    hold_size, cur_size;
  logic [NPORT-1:0][DW-1:0] hold_wdata, cur_wdata;

  // per-port decode
  logic [NPORT-1:0][BW-1:0]    p_bank;
  logic [NPORT-1:0][RW-1:0]    p_row;
  logic [NPORT-1:0][OFFW-1:0]  p_off;
  logic [NPORT-1:0]            p_mis;
  logic [NPORT-1:0][LANES-1:0] p_be;
  logic [NPORT-1:0][DW-1:0]    p_wd;

  logic [NBANK-1:0][NPORT-1:0] pick;
  logic [DW-1:0]               bank_rd [NBANK];

  // response pipeline
  logic [NPORT-1:0]           s1_valid, s1_kill, s1_err;
  logic [NPORT-1:0][BW-1:0]   s1_bank;
  logic [NPORT-1:0][OFFW-1:0] s1_off;
  logic [NPORT-1:0][1:0]      s1_size;
  logic [DW-1:0]              aligned [NPORT];

  assign busy      = |pending;
  assign accept    = issue && !busy;
  assign active    = busy ? pending : (issue ? acc_en : '0);
  assign cur_addr  = busy ? hold_addr : mar_q;
  assign cur_store = busy ? hold_store : acc_store;
  assign cur_size  = busy ? hold_size : acc_size;
  assign cur_wdata = busy ? hold_wdata : acc_wdata;
  assign pend_next = active & ~grant;
  assign stall     = |pend_next;

  always_ff @(posedge clk) begin
    if (rst) pending <= '0;
    else     pending <= pend_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mar_q <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        if (mar_load[p]) mar_q[p] <= mar_value[p*AW +: AW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      hold_addr  <= mar_q;
      hold_store <= acc_store;
      hold_size  <= acc_size;
      hold_wdata <= acc_wdata;
    end
  end

  // address split, store lane enables and lane-replicated store data
  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      p_bank[p] = cur_addr[p][OFFW +: BW];
      p_row[p]  = cur_addr[p][AW-1 -: RW];
      p_off[p]  = cur_addr[p][OFFW-1:0];
      p_mis[p]  = (cur_size[p] == SZ_HALF) && p_off[p][0];
      case (cur_size[p])
        SZ_BYTE: begin
          p_be[p] = LANES'(1) << p_off[p];
          p_wd[p] = {LANES{cur_wdata[p][7:0]}};
        end
        SZ_HALF: begin
          p_be[p] = p_off[p][0] ? '0 : (LANES'(3) << p_off[p]);
          p_wd[p] = {(LANES/2){cur_wdata[p][15:0]}};
        end
        default: begin
          p_be[p] = '1;
          p_wd[p] = cur_wdata[p];
        end
      endcase
    end
  end

  mxb_arbiter #(.NPORT(NPORT), .NBANK(NBANK), .BW(BW)) u_arb (
    .active   (active),
    .bank_sel (p_bank),
    .pick     (pick),
    .grant    (grant)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             en_b, we_b;
    logic [RW-1:0]    row_b;
    logic [DW-1:0]    wd_b;
    logic [LANES-1:0] be_b;

    always_comb begin
      en_b  = |pick[b];
      we_b  = 1'b0;
      row_b = '0;
      wd_b  = '0;
      be_b  = '0;
      for (int p = 0; p < NPORT; p++) begin
        if (pick[b][p]) begin
          we_b  = cur_store[p];
          row_b = p_row[p];
          wd_b  = p_wd[p];
          be_b  = p_be[p];
        end
      end
    end

    mxb_bank #(.DW(DW), .RW(RW)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .en    (en_b),
      .we    (we_b),
      .row   (row_b),
      .wdata (wd_b),
      .be    (be_b),
      .rdata (bank_rd[b])
    );
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NPORT; p++) begin
      s1_bank[p] <= p_bank[p];
      s1_off[p]  <= p_off[p];
      s1_size[p] <= cur_size[p];
      s1_kill[p] <= cur_store[p] || p_mis[p];
      s1_err[p]  <= p_mis[p];
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_align
    mxb_load_align #(.DW(DW), .OFFW(OFFW)) u_align (
      .word   (bank_rd[s1_bank[p]]),
      .off    (s1_off[p]),
      .size   (s1_size[p]),
      .kill   (s1_kill[p]),
      .result (aligned[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= '0;
      resp_valid <= '0;
      resp_err   <= '0;
      resp_data  <= '0;
    end else begin
      s1_valid   <= grant;
      resp_valid <= s1_valid;
      for (int p = 0; p < NPORT; p++) begin
        resp_err[p]              <= s1_valid[p] && s1_err[p];
        resp_data[p*DW +: DW]    <= s1_valid[p] ? aligned[p] : '0;
      end
    end
  end

  // R4: a stalled cycle is always followed by more work on the same bundle
  a_r4_stall_busy: assert property (@(posedge clk) disable iff (rst)
    stall |=> busy);

  // R4: every working cycle retires at least one pending port
  a_r4_progress: assert property (@(posedge clk) disable iff (rst)
    busy |-> (grant != '0));

  // R4: the pending set shrinks strictly while the bundle is served
  a_r4_shrink: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($countones(pending) < $past($countones(pending))));

  // R6: the captured bundle stays put while it is being served
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(hold_addr) && $stable(hold_store) &&
              $stable(hold_size) && $stable(hold_wdata)));

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    // R3: a served port answers exactly two cycles later
    a_r3_resp_latency: assert property (@(posedge clk) disable iff (rst)
      grant[p] |=> ##1 resp_valid[p]);

    // R9: a flagged response carries no data
    a_r9_err_zero: assert property (@(posedge clk) disable iff (rst)
      resp_err[p] |-> (resp_data[p*DW +: DW] == '0));

    // R8: byte loads come back zero-extended
    a_r8_byte_ext: assert property (@(posedge clk) disable iff (rst)
      (s1_valid[p] && (s1_size[p] == SZ_BYTE)) |=>
        (resp_data[p*DW+8 +: DW-8] == '0));
  end

endmodule

// File: tb/bank_xbar_bench.sv
module bank_xbar_bench;
  localparam int NPORT = 4;
  localparam int NBANK = 8;
  localparam int DW    = 32;
  localparam int AW    = 12;
  localparam int ROWS  = 1 << (AW - 5);
  localparam int MEMB  = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NPORT-1:0]    mar_load  = '0;
  logic [NPORT*AW-1:0] mar_value = '0;
  logic                issue     = 1'b0;
  logic [NPORT-1:0]    acc_en    = '0;
  logic [NPORT-1:0]    acc_store = '0;
  logic [NPORT*2-1:0]  acc_size  = '0;
  logic [NPORT*DW-1:0] acc_wdata = '0;
  logic                stall;
  logic [NPORT-1:0]    resp_valid, resp_err;
  logic [NPORT*DW-1:0] resp_data;

  bank_xbar #(.NPORT(NPORT), .NBANK(NBANK), .DW(DW), .AW(AW)) u_bank_xbar (
    .clk, .rst, .mar_load, .mar_value, .issue, .acc_en, .acc_store,
    .acc_size, .acc_wdata, .stall, .resp_valid, .resp_err, .resp_data
  );

  int checks = 0;
  int failures = 0;

  logic [7:0]    model [MEMB];
  logic [AW-1:0] b_addr [NPORT];
  logic          b_en   [NPORT];
  logic          b_st   [NPORT];
  logic [1:0]    b_sz   [NPORT];
  logic [DW-1:0] b_wd   [NPORT];
  int            rank   [NPORT];
  logic [DW-1:0] exp_d  [NPORT];
  logic          exp_e  [NPORT];

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic int bank_of(input logic [AW-1:0] a);
    return int'(a[4:2]);
  endfunction

  // reference effect of one access, in service order
  task automatic model_apply(input int p);
    logic [AW-1:0] a;
    int base;
    a = b_addr[p];
    base = int'(a) & ~3;
    exp_e[p] = (b_sz[p] == 2'd1) && a[0];
    exp_d[p] = '0;
    if (!exp_e[p]) begin
      if (b_st[p]) begin
        case (b_sz[p])
          2'd0: model[a] = b_wd[p][7:0];
          2'd1: begin model[a] = b_wd[p][7:0]; model[a+1] = b_wd[p][15:8]; end
          default: for (int i = 0; i < 4; i++) model[base+i] = b_wd[p][8*i +: 8];
        endcase
      end else begin
        case (b_sz[p])
          2'd0: exp_d[p] = {24'h0, model[a]};
          2'd1: exp_d[p] = {16'h0, model[a+1], model[a]};
          default: exp_d[p] = {model[base+3], model[base+2], model[base+1], model[base]};
        endcase
      end
    end
  endtask

  task automatic drive_bundle(input bit junk);
    issue = 1'b1;
    for (int p = 0; p < NPORT; p++) begin
      acc_en[p]              = junk ? ~b_en[p] : b_en[p];
      acc_store[p]           = junk ? ~b_st[p] : b_st[p];
      acc_size[2*p +: 2]     = junk ? ~b_sz[p] : b_sz[p];
      acc_wdata[p*DW +: DW]  = junk ? ~b_wd[p] : b_wd[p];
    end
  endtask

  task automatic run_bundle(input bit scramble, input bit junkmar);
    int maxocc;
    int ncyc;
    string tg;
    @(negedge clk);
    issue = 1'b0;
    acc_en = '0;
    mar_load = '1;
    for (int p = 0; p < NPORT; p++) mar_value[p*AW +: AW] = b_addr[p];
    maxocc = 0;
    for (int p = 0; p < NPORT; p++) begin
      rank[p] = 0;
      for (int q = 0; q < p; q++)
        if (b_en[q] && bank_of(b_addr[q]) == bank_of(b_addr[p])) rank[p]++;
      if (b_en[p] && rank[p] + 1 > maxocc) maxocc = rank[p] + 1;
    end
    for (int r = 0; r < NPORT; r++)
      for (int p = 0; p < NPORT; p++)
        if (b_en[p] && rank[p] == r) model_apply(p);
    ncyc = (maxocc == 0) ? 1 : maxocc;
    for (int c = 0; c <= ncyc + 1; c++) begin
      @(negedge clk);
      mar_load = '0;
      if (c == 0 && junkmar) begin
        mar_load = '1;
        mar_value = ~mar_value;
      end
      if (c == 0) drive_bundle(1'b0);
      else if (c < ncyc) drive_bundle(scramble);
      else begin issue = 1'b0; acc_en = '0; end
      #1;
      check((maxocc > 1) ? "R4 conflict stall" : "R3 no-conflict stall",
            DW'(stall), DW'(c < maxocc - 1));
      for (int p = 0; p < NPORT; p++) begin
        logic expv;
        expv = b_en[p] && (rank[p] + 2 == c);
        check((rank[p] > 0) ? "R5 response order" : "R3 response timing",
              DW'(resp_valid[p]), DW'(expv));
        if (expv) begin
          check("R9 misaligned flag", DW'(resp_err[p]), DW'(exp_e[p]));
          if (scramble && maxocc > 1) tg = "R6 held bundle data";
          else if (junkmar) tg = "R1 same-cycle address load data";
          else if (b_st[p]) tg = "R11 store response data";
          else if (rank[p] > 0) tg = "R10 bypass and R7 store lanes data";
          else tg = "R2 R8 routed load data";
          check(tg, resp_data[p*DW +: DW], exp_d[p]);
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R12 reset stall", DW'(stall), '0);
    check("R12 reset valid", DW'(resp_valid), '0);
    check("R12 reset err", DW'(resp_err), '0);
    check("R12 reset data", resp_data[DW-1:0], '0);

    // fill every word so later loads see defined contents
    for (int r = 0; r < ROWS; r++) begin
      for (int h = 0; h < 2; h++) begin
        for (int p = 0; p < NPORT; p++) begin
          b_addr[p] = AW'((r << 5) | ((h * 4 + p) << 2));
          b_en[p] = 1'b1;
          b_st[p] = 1'b1;
          b_sz[p] = 2'd2;
          b_wd[p] = 32'h9E37_79B1 * (r * 8 + h * 4 + p + 1);
        end
        run_bundle(1'b0, 1'b0);
      end
    end

    // distinct banks: sizes, offsets, loads and stores on all ports
    for (int k = 0; k < 192; k++) begin
      for (int p = 0; p < NPORT; p++) begin
        int bk, rw, of;
        bk = (k + 2 * p) % 8;
        rw = (k * 5 + p * 37) % ROWS;
        of = ((k >> 2) + p) % 4;
        b_addr[p] = AW'((rw << 5) | (bk << 2) | of);
        b_en[p] = (k % 7) != p;
        b_st[p] = ((k >> 1) ^ p) & 1;
        b_sz[p] = 2'((k + p) % 4);
        b_wd[p] = 32'h7F4A_7C15 * (k * 4 + p + 3);
      end
      run_bundle(1'b0, 1'b0);
    end

    // every bank-collision pattern of four ports over four banks
    for (int k = 0; k < 256; k++) begin
      for (int p = 0; p < NPORT; p++) begin
        int bk, rw, of;
        bk = (k >> (2 * p)) & 3;
        rw = ((k >> 1) + p) & 1;
        of = (k + 3 * p) % 4;
        b_addr[p] = AW'((rw << 5) | (bk << 2) | of);
        b_en[p] = (k % 11) != p + 1;
        b_st[p] = ((k + p) >> 1) & 1;
        b_sz[p] = 2'((k >> p) % 3);
        b_wd[p] = 32'hC2B2_AE35 * (k * 4 + p + 7);
      end
      run_bundle(k[0], (k % 4) == 3);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule